// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the register and arithmetic half of a minimal 8-bit accumulator machine. A single 8-bit bus carries every transfer. A 12-bit control word, supplied each cycle by an external sequencer, selects which unit drives the bus. It also selects which registers capture on the next rising clock edge. The units are:

- a 4-bit program counter;
- a 4-bit memory address register;
- a 16x8 RAM;
- an instruction register, whose upper nibble goes to the sequencer as the opcode;
- an accumulator and a B operand register;
- a two's-complement adder-subtracter;
- an output register that lights eight indicators.

Programs are placed in RAM through a valid/ready write port before a run. The port accepts a word only while the synchronous clear input is high. It holds `prog_ready` low whenever the datapath is running. A word presented without `prog_ready` is dropped rather than held, so the writer must keep `prog_valid` asserted until it sees ready.

Control word bits, from bit 11 down to bit 0, are:

| Bit | Meaning |
|-----|---------|
| 11 | PC increment |
| 10 | PC drives the bus |
| 9 | MAR load, active low |
| 8 | RAM drives the bus, active low |
| 7 | IR load, active low |
| 6 | IR low nibble drives the bus, active low |
| 5 | accumulator load, active low |
| 4 | accumulator drives the bus |
| 3 | subtract select |
| 2 | adder-subtracter drives the bus |
| 1 | B load, active low |
| 0 | output register load, active low |

The idle word, with no driver and no load, is 12'h3E3.

Top module: `accdp_top`

## Requirements
- R1: After `rst_n` is low, every register reads zero: PC, MAR, IR, accumulator, B and output. With the idle word 12'h3E3 the bus reads 8'h00, `leds` reads 8'h00 and `opcode` reads 4'h0.
- R2: With bit 11 high and clear low, the PC advances by one per rising edge, wrapping from 15 to 0. With bit 10 high, the bus shows {4'h0, PC}.
- R3: With `clr` high, the next rising edge zeroes the PC and the IR. This overrides a simultaneous increment (bit 11) or IR load (bit 7).
- R4: With bit 9 low, the MAR captures bus bits [3:0] at the edge. With bit 8 low, the bus shows the RAM byte at the MAR address.
- R5: With bit 7 low, the IR captures the bus. `opcode` always equals IR[7:4]. With bit 6 low, the bus shows {4'h0, IR[3:0]}.
- R6: With bit 5 low, the accumulator captures the bus; otherwise it holds. With bit 4 high, the bus shows the accumulator.
- R7: The adder-subtracter produces (A+B) mod 256 when bit 3 is low and (A-B) mod 256 when bit 3 is high. With bit 2 high, that result is on the bus.
- R8: With bit 1 low, the B register captures the bus; B is observed through the R7 result.
- R9: With bit 0 low, the output register captures the accumulator at the edge; otherwise it holds. `leds` shows the output register.
- R10: With no driver enabled the bus reads 8'h00. At most one of the five drive enables may be active in a cycle.
- R11: `prog_ready` equals `clr`. When `prog_valid` and `prog_ready` are both high, the edge writes `prog_data` to RAM at `prog_addr`. When `clr` is low, `prog_valid` writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of PC and IR; opens the program port |
| ctrl | input | 12 | Control word, bit layout above |
| prog_valid | input | 1 | Program word offered |
| prog_ready | output | 1 | Program word accepted this edge |
| prog_addr | input | 4 | Program word RAM address |
| prog_data | input | 8 | Program word value |
| opcode | output | 4 | IR upper nibble to the sequencer |
| w_bus | output | 8 | Current bus value |
| leds | output | 8 | Output register to indicators |

## Verification
The behaviour hardest to reach from the ports is a complete instruction flow. In it, a value moves RAM to IR to MAR, back through RAM into the accumulator and B, and then through the adder-subtracter. Each hop depends on state that earlier control words left behind. The stimulus first loads a short program and its operands through the program port while clear is held. It then plays a table of fetch and execute control words for a load, an add, a subtract and an output operation, checking the bus and outputs at every step. Wrap-around sums and differences are reached by stepping the PC to an operand address, latching it into the MAR and loading chosen bytes into the accumulator and B.

// File: rtl/accdp_pkg.sv
package accdp_pkg;

  localparam int CTRL_W = 12;

  // Field order is fixed: the sequencer emits the word in this layout.
  typedef struct packed {
    logic pc_inc;     // 11
    logic pc_drv;     // 10
    logic mar_ld_n;   // 9
    logic ram_drv_n;  // 8
    logic ir_ld_n;    // 7
    logic ir_drv_n;   // 6
    logic acc_ld_n;   // 5
    logic acc_drv;    // 4
    logic sub_mode;   // 3
    logic sum_drv;    // 2
    logic b_ld_n;     // 1
    logic out_ld_n;   // 0
  } ctrl_t;

  // Bus source slots.
  localparam int SRC_PC  = 0;
  localparam int SRC_RAM = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_SUM = 4;
  localparam int SRC_N   = 5;

endpackage

// File: rtl/accdp_ldreg.sv
module accdp_ldreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clr)   q <= '0;
    else if (!ld_n) q <= d;
  end
endmodule

// File: rtl/accdp_pc.sv
module accdp_pc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/accdp_ram.sv
module accdp_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/accdp_addsub.sv
module accdp_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_x;

  // Inverting B and injecting a carry forms its two's complement.
  assign b_x = b ^ {W{sub}};
  assign y   = a + b_x + W'(sub);
endmodule

// File: rtl/accdp_bus_mux.sv
module accdp_bus_mux #(
  parameter int W = 8,
  parameter int N = 5
) (
  input  logic [N-1:0]        en,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);
  logic [N-1:0][W-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = src[g] & {W{en[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/accdp_top.sv
module accdp_top #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic [11:0]              ctrl,
  input  logic                     prog_valid,
  output logic                     prog_ready,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [DATA_W-1:0]        prog_data,
  output logic [DATA_W-ADDR_W-1:0] opcode,
  output logic [DATA_W-1:0]        w_bus,
  output logic [DATA_W-1:0]        leds
);
  import accdp_pkg::*;

  localparam int OP_W = DATA_W - ADDR_W;

  ctrl_t c;
  assign c = ctrl;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, acc_q, b_q, ram_rd, sum;
  logic [SRC_N-1:0]  drv_en;
  logic [SRC_N-1:0][DATA_W-1:0] drv_src;

  assign prog_ready = clr;

  accdp_pc #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(c.pc_inc), .q(pc_q)
  );

  accdp_ldreg #(.W(ADDR_W)) u_mar (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld_n(c.mar_ld_n),
    .d(w_bus[ADDR_W-1:0]), .q(mar_q)
  );

  accdp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(prog_valid & prog_ready), .waddr(prog_addr),
    .wdata(prog_data), .raddr(mar_q), .rdata(ram_rd)
  );

  accdp_ldreg #(.W(DATA_W)) u_ir (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld_n(c.ir_ld_n),
    .d(w_bus), .q(ir_q)
  );

  accdp_ldreg #(.W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld_n(c.acc_ld_n),
    .d(w_bus), .q(acc_q)
  );

  accdp_ldreg #(.W(DATA_W)) u_b (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld_n(c.b_ld_n),
    .d(w_bus), .q(b_q)
  );

  accdp_ldreg #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld_n(c.out_ld_n),
    .d(acc_q), .q(leds)
  );

  accdp_addsub #(.W(DATA_W)) u_alu (
    .a(acc_q), .b(b_q), .sub(c.sub_mode), .y(sum)
  );

  assign opcode = ir_q[DATA_W-1 -: OP_W];

  assign drv_en[SRC_PC]   = c.pc_drv;
  assign drv_en[SRC_RAM]  = ~c.ram_drv_n;
  assign drv_en[SRC_IR]   = ~c.ir_drv_n;
  assign drv_en[SRC_ACC]  = c.acc_drv;
  assign drv_en[SRC_SUM]  = c.sum_drv;

  assign drv_src[SRC_PC]  = {{OP_W{1'b0}}, pc_q};
  assign drv_src[SRC_RAM] = ram_rd;
  assign drv_src[SRC_IR]  = {{OP_W{1'b0}}, ir_q[ADDR_W-1:0]};
  assign drv_src[SRC_ACC] = acc_q;
  assign drv_src[SRC_SUM] = sum;

  accdp_bus_mux #(.W(DATA_W), .N(SRC_N)) u_bus (
    .en(drv_en), .src(drv_src), .bus(w_bus)
  );
endmodule

// File: rtl/accdp_chk.sv
module accdp_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic [11:0]              ctrl,
  input logic [DATA_W-1:0]        w_bus,
  input logic [DATA_W-1:0]        leds,
  input logic [DATA_W-ADDR_W-1:0] opcode,
  input logic [ADDR_W-1:0]        pc_q,
  input logic [DATA_W-1:0]        acc_q,
  input logic [DATA_W-1:0]        ir_q
);
  accdp_pkg::ctrl_t c;
  assign c = ctrl;

  // R10: at most one source drives the bus
  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c.pc_drv, ~c.ram_drv_n, ~c.ir_drv_n, c.acc_drv, c.sum_drv}));

  // R10: undriven bus reads zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.pc_drv && c.ram_drv_n && c.ir_drv_n && !c.acc_drv && !c.sum_drv)
      |-> w_bus == '0);

  // R2: counter step
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && c.pc_inc) |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

  // R3: clear wins
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pc_q == '0 && ir_q == '0));

  // R5: opcode follows the captured bus word
  a_r5_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !c.ir_ld_n) |=> opcode == $past(w_bus[DATA_W-1 -: DATA_W-ADDR_W]));

  // R6: accumulator holds without a load
  a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c.acc_ld_n |=> $stable(acc_q));

  // R9: output register takes the accumulator
  a_r9_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    !c.out_ld_n |=> leds == $past(acc_q));

  // R9: output register holds otherwise
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    c.out_ld_n |=> $stable(leds));
endmodule

bind accdp_top accdp_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ctrl(ctrl), .w_bus(w_bus),
  .leds(leds), .opcode(opcode), .pc_q(pc_q), .acc_q(acc_q), .ir_q(ir_q)
);

// File: tb/accdp_top_tb_top.sv
module accdp_top_tb_top;
  localparam logic [11:0] IDLE  = 12'h3E3;
  localparam logic [11:0] C_T1  = 12'h5E3; // PC drives, MAR loads
  localparam logic [11:0] C_INC = 12'hBE3; // PC increment
  localparam logic [11:0] C_PCD = 12'h7E3; // PC drives only
  localparam logic [11:0] C_RAM = 12'h2E3; // RAM drives only
  localparam logic [11:0] C_LDA = 12'h2C3; // RAM -> accumulator
  localparam logic [11:0] C_LDB = 12'h2E1; // RAM -> B
  localparam logic [11:0] C_ADD = 12'h3E7; // sum drives
  localparam logic [11:0] C_SUB = 12'h3EF; // difference drives
  localparam logic [11:0] C_ACD = 12'h3F3; // accumulator drives
  localparam logic [11:0] C_OUT = 12'h3F2; // acc drives, output loads

  // {ctrl[11:0], bus before edge[7:0], leds after[7:0], opcode after[3:0]}
  localparam logic [31:0] VEC [0:23] = '{
    32'h5E3_00_00_0, 32'hBE3_00_00_0, 32'h263_09_00_0, 32'h1A3_09_00_0,
    32'h2C3_10_00_0, 32'h5E3_01_00_0, 32'hBE3_00_00_0, 32'h263_1A_00_1,
    32'h1A3_0A_00_1, 32'h2E1_14_00_1, 32'h3C7_24_00_1, 32'h5E3_02_00_1,
    32'hBE3_00_00_1, 32'h263_2B_00_2, 32'h1A3_0B_00_2, 32'h2E1_18_00_2,
    32'h3CF_0C_00_2, 32'h5E3_03_00_2, 32'hBE3_00_00_2, 32'h263_E0_00_E,
    32'h3F2_0C_0C_E, 32'h5E3_04_0C_E, 32'hBE3_00_0C_E, 32'h263_F0_0C_F
  };

  logic        clk = 1'b0;
  logic        rst_n, clr, prog_valid, prog_ready;
  logic [11:0] ctrl;
  logic [3:0]  prog_addr, opcode;
  logic [7:0]  prog_data, w_bus, leds;

  int unsigned nvec = 0;
  int unsigned nbad = 0;
  int unsigned cycles = 0;

  always #5 clk = ~clk;

  accdp_top dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ctrl(ctrl),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .opcode(opcode), .w_bus(w_bus), .leds(leds)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] c, logic cl);
    @(negedge clk);
    ctrl = c;
    clr  = cl;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(logic [11:0] c, logic cl);
    drive(c, cl);
    tick();
  endtask

  task automatic prog_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    prog_valid = 1'b1;
    prog_addr  = a;
    prog_data  = d;
    tick();
    prog_valid = 1'b0;
  endtask

  task automatic set_pc(int n);
    cyc(IDLE, 1'b1);
    for (int i = 0; i < n; i++) cyc(C_INC, 1'b0);
  endtask

  task automatic fetch_to(int a, logic [11:0] c);
    set_pc(a);
    cyc(C_T1, 1'b0);
    cyc(c, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; ctrl = IDLE;
    prog_valid = 1'b0; prog_addr = '0; prog_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 leds", 32'(leds), 32'h00);
    chk("R1 opcode", 32'(opcode), 32'h0);
    chk("R1 idle bus", 32'(w_bus), 32'h00);
    chk("R11 ready low", 32'(prog_ready), 32'h0);
    drive(C_ACD, 1'b0);
    chk("R1 acc zero", 32'(w_bus), 32'h00);
    drive(C_PCD, 1'b0);
    chk("R1 pc zero", 32'(w_bus), 32'h00);

    // Program load while clear is held
    drive(IDLE, 1'b1);
    chk("R11 ready high", 32'(prog_ready), 32'h1);
    prog_write(4'h0, 8'h09); prog_write(4'h1, 8'h1A);
    prog_write(4'h2, 8'h2B); prog_write(4'h3, 8'hE0);
    prog_write(4'h4, 8'hF0); prog_write(4'h5, 8'h33);
    prog_write(4'h6, 8'hF0); prog_write(4'h7, 8'h20);
    prog_write(4'h8, 8'h05); prog_write(4'h9, 8'h10);
    prog_write(4'hA, 8'h14); prog_write(4'hB, 8'h18);
    prog_write(4'hC, 8'h07);
    cyc(IDLE, 1'b1);

    // Fetch/execute table
    for (int v = 0; v < 24; v++) begin
      drive(VEC[v][31:20], 1'b0);
      chk("R2 R4 R5 R6 R7 R8 R10 table bus", 32'(w_bus), 32'(VEC[v][19:12]));
      tick();
      chk("R9 table leds", 32'(leds), 32'(VEC[v][11:4]));
      chk("R5 table opcode", 32'(opcode), 32'(VEC[v][3:0]));
    end

    // R3: clear beats increment and IR load (IR holds F0, PC is 5)
    cyc(12'hA63, 1'b1);
    chk("R3 ir cleared", 32'(opcode), 32'h0);
    drive(C_PCD, 1'b0);
    chk("R3 pc cleared", 32'(w_bus), 32'h00);

    // R2: wrap past 15
    for (int i = 0; i < 17; i++) cyc(C_INC, 1'b0);
    drive(C_PCD, 1'b0);
    chk("R2 pc wrap", 32'(w_bus), 32'h01);

    // R11: write attempt while running is dropped
    drive(IDLE, 1'b0);
    chk("R11 ready while running", 32'(prog_ready), 32'h0);
    prog_write(4'h5, 8'h77);
    fetch_to(5, C_RAM);
    drive(C_RAM, 1'b0);
    chk("R11 no write while running", 32'(w_bus), 32'h33);
    drive(C_PCD, 1'b0);
    chk("R4 mar address source", 32'(w_bus), 32'h05);

    // R7 R8: wrapping sum and difference
    fetch_to(6, C_LDA);
    fetch_to(7, C_LDB);
    drive(C_ADD, 1'b0);
    chk("R7 sum wraps", 32'(w_bus), 32'h10);
    drive(C_SUB, 1'b0);
    chk("R7 difference", 32'(w_bus), 32'hD0);
    fetch_to(8, C_LDA);
    fetch_to(12, C_LDB);
    drive(C_ADD, 1'b0);
    chk("R8 b loaded sum", 32'(w_bus), 32'h0C);
    drive(C_SUB, 1'b0);
    chk("R7 negative difference", 32'(w_bus), 32'hFE);

    // R9 R6: output load, then hold across an accumulator change
    cyc(C_OUT, 1'b0);
    chk("R9 out load", 32'(leds), 32'h05);
    fetch_to(6, C_LDA);
    chk("R9 out hold", 32'(leds), 32'h05);
    drive(C_ACD, 1'b0);
    chk("R6 acc drive", 32'(w_bus), 32'hF0);
    cyc(IDLE, 1'b0);
    drive(C_ACD, 1'b0);
    chk("R6 acc hold", 32'(w_bus), 32'hF0);
    cyc(C_OUT, 1'b0);
    chk("R9 out reload", 32'(leds), 32'hF0);
    drive(IDLE, 1'b0);
    chk("R10 idle bus", 32'(w_bus), 32'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule